// File: doc/BRIEF.md
# I2C Register-File Target with Power-Fail Lockout

This block is an I2C target that lives on a fast system clock. It oversamples the SCL and SDA lines and answers one fixed 7-bit device address, 68h. On the wire that address appears as D0h for a write and as D1h for a read. Behind the bus logic sits a small byte-wide register file. The bus reaches it through a pointer that steps forward by one after every data byte. The host side of the chip reads and writes the same storage through a plain parallel port.

A bus master writes by sending the address byte, then a pointer byte, then any number of data bytes. It reads either straight after addressing, in which case the read starts at the current pointer, or after a repeated START that follows a pointer byte. SDA is driven open-drain: the block only ever pulls the line low.

A power-fail input overrides everything else. It aborts the transfer in progress and clears the pointer. For as long as it is asserted, the block ignores all bus activity and makes no register writes.

Top module: `i2c_regfile_target`

## Requirements
- R1: Only an address byte of D0h (write) or D1h (read), that is device address 68h in bits 7:1 with the read flag in bit 0, receives an ACK. After any other address byte the block sends no ACK, writes nothing and ignores all bytes until the next START.
- R2: After a matching address, the block ACKs every byte it receives: the address byte, the pointer byte and each data byte. It does this by holding SDA low through the whole high phase of the ninth clock.
- R3: In a write transfer, the first byte after the address loads the pointer. A value of NUM_REGS or more loads 0.
- R4: Each later byte in a write transfer is stored at the pointer, and the pointer then advances by one, wrapping from NUM_REGS-1 to 0.
- R5: In a read transfer, the block sends the register at the pointer MSB first, changing SDA only while SCL is low. The pointer advances by one after each byte, with the same wrap as in R4.
- R6: After the master answers a read byte with NACK, the block releases SDA and drives nothing more until the next START.
- R7: A STOP that arrives part-way through a byte abandons that byte. Nothing is written, the pointer is unchanged, and a later START is answered normally.
- R8: Asserting pwr_fail ends any access in progress, sets the pointer to 0 and releases SDA within two clock cycles.
- R9: While pwr_fail is high, no byte is ACKed and no register is written by the bus. After pwr_fail falls, the block waits for a new START.
- R10: Reset clears every register to 0. When host_we is high, host_wdata is stored at host_addr on the clock edge. host_rdata always shows the register at host_addr. If the host and the bus write in the same cycle, the bus write wins.
- R11: sda_oe set to 1 means pull SDA low, and sda_oe set to 0 means release it. sda_oe is 0 during and straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fail | input | 1 | Supply-failure lockout, active high |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| host_we | input | 1 | Host write strobe |
| host_addr | input | PTR_W | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register contents at host_addr |

## Verification
The bench builds the block with its defaults: 20 registers, device address 68h and two synchronizer stages. With a map this small, one write burst and one read burst cover every register and both wrap points. The bench also sweeps all 128 seven-bit addresses with trailing data bytes, which checks that non-matching addresses get no ACK and cause no stray writes. Further cases cover an out-of-range pointer byte, a STOP in the middle of a byte, and pwr_fail asserted in the middle of a byte. In every case the expected register contents come from a simple array model in the bench.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int              BYTE_W           = 8;
    localparam logic [6:0]      DEFAULT_DEV_ADDR = 7'h68;
    localparam int              DEFAULT_NUM_REGS = 20;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_DATA,
        ST_ACK_ADDR,
        ST_ACK_PTR,
        ST_ACK_DATA,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } tgt_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_rf_line_sync.sv
module i2c_rf_line_sync
    import i2c_rf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.sda      = sda_s;
    end

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs at least two stages");
    end

endmodule

// File: rtl/i2c_rf_proto.sv
module i2c_rf_proto
    import i2c_rf_pkg::*;
#(
    parameter int          NUM_REGS = DEFAULT_NUM_REGS,
    parameter logic [6:0]  DEV_ADDR = DEFAULT_DEV_ADDR,
    localparam int         PTR_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_fail,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

    tgt_state_t        state;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [3:0]        bit_cnt;
    logic              is_read;
    logic              nack;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rx_sh   <= '0;
            tx_sh   <= '0;
            bit_cnt <= '0;
            is_read <= 1'b0;
            nack    <= 1'b0;
            sda_oe  <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (pwr_fail) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                ptr     <= '0;
                bit_cnt <= '0;
            end else if (evt.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_DATA: begin
                        if (evt.scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], evt.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (evt.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(rx_sh, DEV_ADDR)) begin
                                    is_read <= rx_sh[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK_ADDR;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_PTR) begin
                                ptr    <= (int'(rx_sh) < NUM_REGS) ? rx_sh[PTR_W-1:0] : '0;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK_PTR;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= rx_sh;
                                ptr     <= step(ptr);
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK_DATA;
                            end
                        end
                    end
                    ST_ACK_ADDR: begin
                        if (evt.scl_fall) begin
                            if (is_read) begin
                                tx_sh   <= rd_data;
                                sda_oe  <= ~rd_data[BYTE_W-1];
                                bit_cnt <= '0;
                                state   <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_PTR;
                            end
                        end
                    end
                    ST_ACK_PTR, ST_ACK_DATA: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_DATA;
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                ptr    <= step(ptr);
                                state  <= ST_MACK;
                            end else begin
                                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~tx_sh[BYTE_W-2];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.scl_rise) begin
                            nack <= evt.sda;
                        end else if (evt.scl_fall) begin
                            if (nack) begin
                                state <= ST_SKIP;
                            end else begin
                                tx_sh   <= rd_data;
                                sda_oe  <= ~rd_data[BYTE_W-1];
                                bit_cnt <= '0;
                                state   <= ST_TX;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_ACK_ONLY_MATCH: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && state == ST_ACK_ADDR) |-> addr_hit(rx_sh, DEV_ADDR))
        else $error("address ACK without match"); // R1
    AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (sda_oe && state == ST_ACK_DATA))
        else $error("write outside a data ACK"); // R4
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST_IDX)
        else $error("pointer out of range"); // R4
    AST_QUIET_STATES: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_SKIP || state == ST_MACK) |-> !sda_oe)
        else $error("SDA driven while not allowed"); // R6
    AST_PF_ABORT: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_fail) |-> (ptr == '0 && !sda_oe && state == ST_IDLE))
        else $error("power fail did not abort"); // R8
    AST_PF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_fail) |-> !wr_en)
        else $error("write during power fail"); // R9

endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store
    import i2c_rf_pkg::*;
#(
    parameter int  NUM_REGS = DEFAULT_NUM_REGS,
    localparam int PTR_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              host_we,
    input  logic [PTR_W-1:0]  host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] host_rdata
);

    logic [BYTE_W-1:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (wr_en && int'(wr_addr) == g) begin
                mem[g] <= wr_data;
            end else if (host_we && int'(host_addr) == g) begin
                mem[g] <= host_wdata;
            end
        end
    end

    assign rd_data    = (int'(rd_addr) < NUM_REGS) ? mem[rd_addr] : '0;
    assign host_rdata = (int'(host_addr) < NUM_REGS) ? mem[host_addr] : '0;

    AST_BUS_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)))
        else $error("bus write lost"); // R10

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = DEFAULT_DEV_ADDR,
    parameter int         NUM_REGS    = DEFAULT_NUM_REGS,
    parameter int         SYNC_STAGES = 2,
    localparam int        PTR_W       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_fail,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              host_we,
    input  logic [PTR_W-1:0]  host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata
);

    bus_evt_t          evt;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;

    i2c_rf_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_rf_proto #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_proto (
        .clk      (clk),
        .rst      (rst),
        .pwr_fail (pwr_fail),
        .evt      (evt),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    i2c_rf_store #(.NUM_REGS(NUM_REGS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .rd_addr    (ptr),
        .rd_data    (rd_data),
        .host_rdata (host_rdata)
    );

    AST_RESET_RELEASE: assert property (@(posedge clk)
        $past(rst) |-> !sda_oe)
        else $error("SDA driven after reset"); // R11

endmodule

// File: tb/test_i2c_regfile_target.sv
module test_i2c_regfile_target;

    localparam int NREG = 20;
    localparam int Q    = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_fail = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       sda_oe;
    logic [7:0] host_rdata;
    logic       sda_line;

    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    logic [7:0] model [NREG];

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_regfile_target i_i2c_regfile_target (
        .clk        (clk),
        .rst        (rst),
        .pwr_fail   (pwr_fail),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; qwait();
            scl_m = 1'b1; qwait(); qwait();
            scl_m = 1'b0; qwait();
        end
    endtask

    task automatic ack_clock(output logic acked);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        acked = ~sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        ack_clock(acked);
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            qwait();
            scl_m = 1'b1; qwait();
            d[7-i] = sda_line; qwait();
            scl_m = 1'b0; qwait();
        end
        sda_m = ~master_ack; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
        sda_m = 1'b1;
    endtask

    task automatic host_read(input int a, output logic [7:0] d);
        host_addr = 5'(a);
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic host_write(input int a, input logic [7:0] v);
        @(negedge clk);
        host_addr = 5'(a); host_wdata = v; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic scan_regs(input string req);
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) begin
            host_read(i, d);
            chk(req, d, model[i]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R11 / R10: reset state
        chk("R11 sda_oe after reset", sda_oe, 1'b0);
        scan_regs("R10 reset clears registers");

        // R1: sweep all 7-bit addresses, write direction, with two trailing bytes
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            chk("R1 address ack", ack, a == 8'h68);
            send_byte(8'h02, ack);
            chk("R1 pointer byte ack", ack, a == 8'h68);
            send_byte(8'hA5, ack);
            chk("R1 data byte ack", ack, a == 8'h68);
            bus_stop();
        end
        model[2] = 8'hA5;
        scan_regs("R1 no stray writes");

        // R2 R3 R4: full sequential write from 0
        bus_start();
        send_byte(8'hD0, ack); chk("R2 write address ack", ack, 1'b1);
        send_byte(8'h00, ack); chk("R3 pointer ack", ack, 1'b1);
        for (int i = 0; i < NREG; i++) begin
            send_byte(8'(i * 37 + 5), ack);
            chk("R2 data ack", ack, 1'b1);
            model[i] = 8'(i * 37 + 5);
        end
        bus_stop();
        scan_regs("R4 sequential write");

        // R4: pointer wraps from last register to 0
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd18, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        bus_stop();
        model[18] = 8'h11; model[19] = 8'h22; model[0] = 8'h33;
        scan_regs("R4 write wrap");

        // R3: out-of-range pointer loads 0
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd200, ack); chk("R3 out-of-range pointer ack", ack, 1'b1);
        send_byte(8'h3C, ack);
        bus_stop();
        model[0] = 8'h3C;
        host_read(0, d); chk("R3 out-of-range pointer loads 0", d, 8'h3C);
        host_read(1, d); chk("R3 neighbour untouched", d, model[1]);

        // R5 R6: random read via repeated start, NACK ends data
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd7, ack);
        bus_start();
        send_byte(8'hD1, ack); chk("R5 read address ack", ack, 1'b1);
        recv_byte(1'b1, d); chk("R5 random read byte 0", d, model[7]);
        recv_byte(1'b1, d); chk("R5 random read byte 1", d, model[8]);
        recv_byte(1'b0, d); chk("R5 random read byte 2", d, model[9]);
        repeat (8) @(negedge clk);
        chk("R6 released after NACK", sda_oe, 1'b0);
        recv_byte(1'b0, d); chk("R6 no drive after NACK", d, 8'hFF);
        bus_stop();

        // R5: sequential read across the wrap
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd15, ack);
        bus_start();
        send_byte(8'hD1, ack);
        for (int k = 0; k < 22; k++) begin
            recv_byte(k != 21, d);
            chk("R5 sequential read", d, model[(15 + k) % NREG]);
        end
        bus_stop();

        // R10: host write seen by the bus
        host_write(11, 8'h9E);
        model[11] = 8'h9E;
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd11, ack);
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(1'b0, d); chk("R10 host write read by bus", d, 8'h9E);
        bus_stop();

        // R7: STOP in the middle of a data byte
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd2, ack);
        send_bits(8'hF0, 4);
        bus_stop();
        host_read(2, d); chk("R7 partial byte not written", d, model[2]);
        bus_start();
        send_byte(8'hD1, ack); chk("R7 new START answered", ack, 1'b1);
        recv_byte(1'b0, d); chk("R7 pointer unchanged", d, model[2]);
        bus_stop();

        // R8 R9: power fail in the middle of a data byte
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'd4, ack);
        send_bits(8'h77, 3);
        pwr_fail = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 SDA released on power fail", sda_oe, 1'b0);
        send_bits(8'hB8, 5);
        ack_clock(ack); chk("R9 no ACK during power fail", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hD0, ack); chk("R9 address ignored during power fail", ack, 1'b0);
        send_byte(8'd4, ack);
        send_byte(8'h99, ack);
        bus_stop();
        pwr_fail = 1'b0;
        repeat (4) @(negedge clk);
        scan_regs("R9 no writes during power fail");
        bus_start();
        send_byte(8'hD1, ack); chk("R9 accepted after power fail", ack, 1'b1);
        recv_byte(1'b0, d); chk("R8 pointer reset to 0", d, model[0]);
        bus_stop();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule